// File: doc/BRIEF.md
# Received Frame Group Classifier

This block sorts each received frame into one of forty software group codes, so that later stages can steer and count frames by class without decoding the frame-control header again. The receive path presents the header's protocol version, frame type and subtype, together with four flags from the PHY and address logic: a PHY error, a null data packet (NDP), a group-addressed destination and a trigger-based or uplink multi-user PPDU. All of these arrive with a single-cycle input strobe.

The classifier tests the frame against a fixed list of categories in priority order. The first category that matches sets the code. The code is registered and appears on the cycle after the strobe, with an output strobe that is high for that one cycle only. Between strobes the code register keeps its last value. The frame type is encoded as management = 0, control = 1, data = 2 and reserved = 3.

Top module: `fgc_classifier`

## Requirements
- R1: While reset is held and on the first cycle after it is released, out_valid is 0 and out_group is 0.
- R2: out_valid is 1 in exactly the cycle after each cycle in which in_valid is sampled high, and 0 in every other cycle. out_group changes only in those cycles and otherwise holds its previous value.
- R3: A frame with in_phy_err = 1 gets code 37, whatever the other inputs are.
- R4: A frame with in_ndp = 1 and no PHY error gets code 0. This holds even if its type or version is unsupported.
- R5: A frame with no PHY error and no NDP flag, whose type is 3 or whose protocol version is not 0, gets code 36.
- R6: A supported data frame (type 2) with subtype 4 (Null) gets code 3. The multicast flag and the trigger-based flag have no effect on it.
- R7: A supported data frame with subtype 12 (QoS Null) gets code 39 when in_tb_ppdu = 1 and code 38 otherwise.
- R8: Any other supported data frame gets code 1 when in_mcast = 1 and code 2 otherwise. in_tb_ppdu has no effect on it.
- R9: A supported management frame (type 0) gets code 4 + subtype, which covers codes 4 to 19.
- R10: A supported control frame (type 1) gets code 20 + subtype, which covers codes 20 to 35.
- R11: Every code presented with out_valid = 1 lies in the range 0 to 39.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle strobe: the frame fields below are valid |
| in_proto_ver | input | 2 | Protocol version field of frame control |
| in_ftype | input | 2 | Frame type: 0 mgmt, 1 ctrl, 2 data, 3 reserved |
| in_subtype | input | 4 | Frame subtype field |
| in_phy_err | input | 1 | PHY reported an error for this frame |
| in_ndp | input | 1 | Frame is a null data packet |
| in_mcast | input | 1 | Destination address is group addressed |
| in_tb_ppdu | input | 1 | Frame came in a trigger-based or uplink MU PPDU |
| out_valid | output | 1 | One-cycle strobe: out_group holds a new code |
| out_group | output | 7 | Software group code, 0 to 39 |

## Verification
The bench goes after the points where two categories overlap. A PHY error on an NDP must still give 37, and an NDP with a reserved type must still give 0; a design with the priority order swapped returns the lower-priority code instead. A non-zero version on a Null or QoS Null subtype must give 36 and not 3 or 38. The bench also checks that the trigger-based flag changes only QoS Null and never Null or ordinary data, and that the multicast flag is ignored for Null. It sweeps every subtype of management and control frames, which exposes an adder with the wrong base or a missing carry into bit 4 or bit 5. Finally, it checks that the code holds and the strobe stays low between frames, and that frames sent back to back each give their own code.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

  localparam int VER_W   = 2;
  localparam int TYPE_W  = 2;
  localparam int SUB_W   = 4;
  localparam int CODE_W  = 7;

  localparam logic [TYPE_W-1:0] FT_MGMT = 2'd0;
  localparam logic [TYPE_W-1:0] FT_CTRL = 2'd1;
  localparam logic [TYPE_W-1:0] FT_DATA = 2'd2;
  localparam logic [TYPE_W-1:0] FT_RSVD = 2'd3;

  localparam logic [SUB_W-1:0] SUB_NULL  = 4'd4;
  localparam logic [SUB_W-1:0] SUB_QNULL = 4'd12;

  localparam logic [CODE_W-1:0] GC_NDP       = 7'd0;
  localparam logic [CODE_W-1:0] GC_MCAST     = 7'd1;
  localparam logic [CODE_W-1:0] GC_UCAST     = 7'd2;
  localparam logic [CODE_W-1:0] GC_NULL      = 7'd3;
  localparam logic [CODE_W-1:0] GC_MGMT_BASE = 7'd4;
  localparam logic [CODE_W-1:0] GC_CTRL_BASE = 7'd20;
  localparam logic [CODE_W-1:0] GC_UNSUP     = 7'd36;
  localparam logic [CODE_W-1:0] GC_PHYERR    = 7'd37;
  localparam logic [CODE_W-1:0] GC_QNULL     = 7'd38;
  localparam logic [CODE_W-1:0] GC_QNULL_TB  = 7'd39;
  localparam logic [CODE_W-1:0] GC_MAX       = 7'd39;

  // Categories, listed from highest to lowest priority.
  typedef enum logic [2:0] {
    K_PHYERR = 3'd0,
    K_NDP    = 3'd1,
    K_UNSUP  = 3'd2,
    K_NULL   = 3'd3,
    K_QNULL  = 3'd4,
    K_DATA   = 3'd5,
    K_MGMT   = 3'd6,
    K_CTRL   = 3'd7
  } fgc_kind_e;

  localparam int NUM_KINDS = 8;

  typedef struct packed {
    logic [VER_W-1:0]  ver;
    logic [TYPE_W-1:0] ftype;
    logic [SUB_W-1:0]  sub;
    logic              phy_err;
    logic              ndp;
    logic              mcast;
    logic              tb;
  } fgc_in_t;

  // Codes for management and control frames: base plus subtype.
  function automatic logic [CODE_W-1:0] fgc_offset_code(
      input logic [CODE_W-1:0] base, input logic [SUB_W-1:0] sub);
    return base + {{(CODE_W-SUB_W){1'b0}}, sub};
  endfunction

  function automatic logic fgc_supported(input fgc_in_t f);
    return (f.ver == '0) && (f.ftype != FT_RSVD);
  endfunction

endpackage

// File: rtl/fgc_decode.sv
module fgc_decode
  import fgc_pkg::*;
(
  input  fgc_in_t              f,
  output logic [NUM_KINDS-1:0] hits
);
  logic supp;
  logic is_data;

  assign supp    = fgc_supported(f);
  assign is_data = supp && (f.ftype == FT_DATA);

  always_comb begin
    hits           = '0;
    hits[K_PHYERR] = f.phy_err;
    hits[K_NDP]    = f.ndp;
    hits[K_UNSUP]  = !supp;
    hits[K_NULL]   = is_data && (f.sub == SUB_NULL);
    hits[K_QNULL]  = is_data && (f.sub == SUB_QNULL);
    hits[K_DATA]   = is_data;
    hits[K_MGMT]   = supp && (f.ftype == FT_MGMT);
    hits[K_CTRL]   = supp && (f.ftype == FT_CTRL);
  end
endmodule

// File: rtl/fgc_prio.sv
module fgc_prio
  import fgc_pkg::*;
(
  input  logic [NUM_KINDS-1:0] hits,
  input  fgc_in_t              f,
  output fgc_kind_e            win,
  output logic [CODE_W-1:0]    code
);
  // Lowest index set wins.
  always_comb begin
    win = K_UNSUP;
    for (int i = NUM_KINDS - 1; i >= 0; i--) begin
      if (hits[i]) win = fgc_kind_e'(i[2:0]);
    end
  end

  always_comb begin
    unique case (win)
      K_PHYERR: code = GC_PHYERR;
      K_NDP:    code = GC_NDP;
      K_UNSUP:  code = GC_UNSUP;
      K_NULL:   code = GC_NULL;
      K_QNULL:  code = f.tb ? GC_QNULL_TB : GC_QNULL;
      K_DATA:   code = f.mcast ? GC_MCAST : GC_UCAST;
      K_MGMT:   code = fgc_offset_code(GC_MGMT_BASE, f.sub);
      K_CTRL:   code = fgc_offset_code(GC_CTRL_BASE, f.sub);
      default:  code = GC_UNSUP;
    endcase
  end
endmodule

// File: rtl/fgc_classifier.sv
module fgc_classifier
  import fgc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [VER_W-1:0]    in_proto_ver,
  input  logic [TYPE_W-1:0]   in_ftype,
  input  logic [SUB_W-1:0]    in_subtype,
  input  logic                in_phy_err,
  input  logic                in_ndp,
  input  logic                in_mcast,
  input  logic                in_tb_ppdu,
  output logic                out_valid,
  output logic [CODE_W-1:0]   out_group
);
  fgc_in_t              fin;
  logic [NUM_KINDS-1:0] hits;
  fgc_kind_e            win;
  logic [CODE_W-1:0]    next_code;
  logic                 capture;

  assign fin = '{ver: in_proto_ver, ftype: in_ftype, sub: in_subtype,
                 phy_err: in_phy_err, ndp: in_ndp, mcast: in_mcast,
                 tb: in_tb_ppdu};

  assign capture = in_valid;

  fgc_decode u_dec (.f(fin), .hits(hits));

  fgc_prio u_prio (.hits(hits), .f(fin), .win(win), .code(next_code));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_group <= '0;
    end else begin
      out_valid <= capture;
      if (capture) out_group <= next_code;
    end
  end
endmodule

// File: rtl/fgc_checker.sv
module fgc_checker
  import fgc_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [VER_W-1:0]    in_proto_ver,
  input logic [TYPE_W-1:0]   in_ftype,
  input logic [SUB_W-1:0]    in_subtype,
  input logic                in_phy_err,
  input logic                in_ndp,
  input logic                in_mcast,
  input logic                in_tb_ppdu,
  input logic [NUM_KINDS-1:0] hits,
  input fgc_kind_e           win,
  input logic                out_valid,
  input logic [CODE_W-1:0]   out_group
);
  logic supp;
  assign supp = (in_proto_ver == '0) && (in_ftype != FT_RSVD);

  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_group));
  a_r3_phy_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_phy_err) |=> (out_group == GC_PHYERR));
  a_r4_ndp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_phy_err && in_ndp) |=> (out_group == GC_NDP));
  a_r5_unsup: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_phy_err && !in_ndp && !supp) |=> (out_group == GC_UNSUP));
  a_r7_qnull_tb: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_phy_err && !in_ndp && supp && in_ftype == FT_DATA &&
     in_subtype == SUB_QNULL && in_tb_ppdu) |=> (out_group == GC_QNULL_TB));
  a_r9_mgmt: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_phy_err && !in_ndp && supp && in_ftype == FT_MGMT)
      |=> (out_group == GC_MGMT_BASE + {3'b000, $past(in_subtype)}));
  a_r10_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_phy_err && !in_ndp && supp && in_ftype == FT_CTRL)
      |=> (out_group == GC_CTRL_BASE + {3'b000, $past(in_subtype)}));
  a_r11_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_group <= GC_MAX));
  a_r3_winner_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hits[win]);
endmodule

bind fgc_classifier fgc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .in_proto_ver(in_proto_ver), .in_ftype(in_ftype), .in_subtype(in_subtype),
  .in_phy_err(in_phy_err), .in_ndp(in_ndp), .in_mcast(in_mcast),
  .in_tb_ppdu(in_tb_ppdu), .hits(hits), .win(win),
  .out_valid(out_valid), .out_group(out_group)
);

// File: tb/fgc_classifier_tb.sv
module fgc_classifier_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_proto_ver = '0;
  logic [1:0] in_ftype = '0;
  logic [3:0] in_subtype = '0;
  logic       in_phy_err = 1'b0;
  logic       in_ndp = 1'b0;
  logic       in_mcast = 1'b0;
  logic       in_tb_ppdu = 1'b0;
  logic       out_valid;
  logic [6:0] out_group;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fgc_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_proto_ver(in_proto_ver), .in_ftype(in_ftype), .in_subtype(in_subtype),
    .in_phy_err(in_phy_err), .in_ndp(in_ndp), .in_mcast(in_mcast),
    .in_tb_ppdu(in_tb_ppdu), .out_valid(out_valid), .out_group(out_group)
  );

  // Reference model: lowest priority first, later rules override.
  function automatic int ref_code(int ver, int ft, int sub, bit pe, bit nd,
                                  bit mc, bit tb);
    int c;
    if (ft == 0)      c = 4 + sub;
    else if (ft == 1) c = 20 + sub;
    else              c = mc ? 1 : 2;
    if (ft == 2 && sub == 12) c = tb ? 39 : 38;
    if (ft == 2 && sub == 4)  c = 3;
    if (ft == 3 || ver != 0)  c = 36;
    if (nd) c = 0;
    if (pe) c = 37;
    return c;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One frame: strobe at a negedge, look one negedge later.
  task automatic send(string req, int ver, int ft, int sub, bit pe, bit nd,
                      bit mc, bit tb);
    @(negedge clk);
    in_valid = 1'b1; in_proto_ver = ver[1:0]; in_ftype = ft[1:0];
    in_subtype = sub[3:0]; in_phy_err = pe; in_ndp = nd;
    in_mcast = mc; in_tb_ppdu = tb;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " strobe"}, int'(out_valid), 1);
    check(req, int'(out_group), ref_code(ver, ft, sub, pe, nd, mc, tb));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 group in reset", int'(out_group), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(out_valid), 0);
    check("R1 group after reset", int'(out_group), 0);
  endtask

  task automatic t_priority();
    send("R3 phy err on ndp", 0, 2, 0, 1, 1, 1, 1);
    send("R3 phy err on reserved type", 2, 3, 7, 1, 0, 0, 0);
    send("R3 phy err on mgmt", 0, 0, 5, 1, 0, 0, 0);
    send("R4 ndp with reserved type", 0, 3, 0, 0, 1, 0, 0);
    send("R4 ndp with bad version", 1, 2, 4, 0, 1, 1, 0);
    send("R5 reserved type", 0, 3, 9, 0, 0, 0, 0);
    send("R5 version on null", 3, 2, 4, 0, 0, 0, 0);
    send("R5 version on qos null", 1, 2, 12, 0, 0, 0, 1);
  endtask

  task automatic t_data();
    send("R6 null ucast", 0, 2, 4, 0, 0, 0, 0);
    send("R6 null mcast tb", 0, 2, 4, 0, 0, 1, 1);
    send("R7 qos null", 0, 2, 12, 0, 0, 0, 0);
    send("R7 qos null tb", 0, 2, 12, 0, 0, 1, 1);
    send("R8 data ucast", 0, 2, 0, 0, 0, 0, 0);
    send("R8 data mcast", 0, 2, 8, 0, 0, 1, 0);
    send("R8 data ucast tb", 0, 2, 8, 0, 0, 0, 1);
  endtask

  task automatic t_mgmt_ctrl();
    for (int s = 0; s < 16; s++) send("R9 mgmt subtype", 0, 0, s, 0, 0, s[0], s[1]);
    for (int s = 0; s < 16; s++) send("R10 ctrl subtype", 0, 1, s, 0, 0, s[1], s[0]);
  endtask

  task automatic t_timing();
    int held;
    send("R2 first frame", 0, 1, 15, 0, 0, 0, 0);
    held = int'(out_group);
    repeat (3) begin
      @(negedge clk);
      check("R2 strobe idle", int'(out_valid), 0);
      check("R2 code held", int'(out_group), held);
    end
    // Back-to-back frames.
    @(negedge clk);
    in_valid = 1'b1; in_ftype = 2'd0; in_subtype = 4'd2; in_proto_ver = 2'd0;
    in_phy_err = 0; in_ndp = 0; in_mcast = 0; in_tb_ppdu = 0;
    @(negedge clk);
    check("R2 b2b first strobe", int'(out_valid), 1);
    check("R2 b2b first code", int'(out_group), 6);
    in_ftype = 2'd2; in_subtype = 4'd12; in_tb_ppdu = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 b2b second strobe", int'(out_valid), 1);
    check("R2 b2b second code", int'(out_group), 39);
    @(negedge clk);
    check("R2 b2b quiet", int'(out_valid), 0);
  endtask

  task automatic t_sweep();
    for (int v = 0; v < 4096; v++) begin
      send("R11 sweep", v[1:0], v[3:2], v[7:4], v[8], v[9], v[10], v[11]);
      if (out_group > 7'd39) check("R11 range", int'(out_group), 39);
    end
  endtask

  initial begin
    t_reset();
    t_priority();
    t_data();
    t_mgmt_ctrl();
    t_timing();
    t_sweep();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule